// File: doc/BRIEF.md
# Balanced-Matrix SEC-DED Codec for a 4-Bit Nibble

This block protects a 4-bit data nibble with four check bits to form an 8-bit codeword. It corrects any one flipped bit in that word and flags any two flipped bits. The parity-check matrix is balanced: every check equation XORs exactly three data bits. As a result, all four parity trees have the same fan-in and the same depth.

The block has two independent paths that share one clock. The encode path takes a nibble and returns its codeword. The decode path takes a received codeword and returns four outputs: the corrected nibble, the 4-bit syndrome, a single-error flag and a double-error flag.

Errors are classified by syndrome weight alone; there is no overall parity bit. A syndrome of odd weight is a correctable single error. A nonzero syndrome of even weight is an uncorrectable double error. Both paths register their outputs. Each result appears one clock after its input strobe, together with an output strobe.

Top module: `secded4_codec`

## Requirements
- R1: The codeword, listed from bit 7 down to bit 0, is {P1, P2, D3, P4, D5, D6, D7, P8}. The nibble maps as data[3]=D3, data[2]=D5, data[1]=D6 and data[0]=D7. The check bits are P1=D3^D5^D6, P2=D3^D5^D7, P4=D3^D6^D7 and P8=D5^D6^D7.
- R2: The encode output register updates on the clock edge that samples `enc_vld_i` high. `enc_vld_o` is high exactly in the cycle after `enc_vld_i` was high. Both strobes are low after reset.
- R3: The syndrome is {C8,C4,C2,C1}, with C8 in bit 3 and C1 in bit 0. Each Cx is the XOR of received Px with the three received data bits that make up Px.
- R4: A received word with a zero syndrome returns its data bits unchanged, with both flags low.
- R5: A syndrome of weight 1 marks a flipped check bit. The data bits are returned unchanged and the single-error flag is set.
- R6: A syndrome of weight 3 names a flipped data bit: 0111 means D3, 1011 means D5, 1101 means D6 and 1110 means D7. That bit is inverted on the output and the single-error flag is set.
- R7: A nonzero syndrome of even weight reports a double error. The double-error flag is set, the single-error flag stays low, and the received data bits are passed through uncorrected.
- R8: `dec_vld_o` is high exactly in the cycle after `dec_vld_i` was high. It is low after reset and during idle cycles.
- R9: The single-error and double-error flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_vld_i | input | 1 | Nibble on `enc_data_i` is valid |
| enc_data_i | input | 4 | Nibble to encode |
| enc_vld_o | output | 1 | `enc_word_o` is valid |
| enc_word_o | output | 8 | Encoded codeword |
| dec_vld_i | input | 1 | Word on `dec_word_i` is valid |
| dec_word_i | input | 8 | Received codeword |
| dec_vld_o | output | 1 | Decode outputs are valid |
| dec_data_o | output | 4 | Corrected nibble |
| dec_syn_o | output | 4 | Syndrome {C8,C4,C2,C1} |
| dec_sec_o | output | 1 | Single error seen and corrected |
| dec_ded_o | output | 1 | Double error seen, data uncorrected |

## Verification
The assertions check the following on every cycle:
- the one-cycle strobe relation on both paths;
- that the two flags are mutually exclusive;
- that a zero syndrome raises no flag;
- that the flag parity agrees with the syndrome weight;
- that a weight-1 syndrome leaves the data bits untouched.

Only the bench scenarios can show whether the check equations, the bit order, the syndrome values and the choice of which data bit gets inverted are right. To cover them, the bench encodes all 16 nibbles. For each codeword it then decodes the clean word, all 8 single flips and all 28 double flips, and inserts idle gaps to exercise the strobes.

// File: rtl/secded4_pkg.sv
// Shared widths, codeword bit positions and nibble bit positions for the
// balanced SEC-DED codec. Assumes the fixed 4-data/4-check layout.
package secded4_pkg;
    localparam int DATA_W = 4;
    localparam int CHK_W  = 4;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int SYN_W  = CHK_W;

    // Codeword bit positions (bit 7 is the first listed).
    localparam int POS_P1 = 7;
    localparam int POS_P2 = 6;
    localparam int POS_D3 = 5;
    localparam int POS_P4 = 4;
    localparam int POS_D5 = 3;
    localparam int POS_D6 = 2;
    localparam int POS_D7 = 1;
    localparam int POS_P8 = 0;

    // Nibble bit positions.
    localparam int NIB_D3 = 3;
    localparam int NIB_D5 = 2;
    localparam int NIB_D6 = 1;
    localparam int NIB_D7 = 0;

    typedef logic [DATA_W-1:0] nib_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SYN_W-1:0]  syn_t;

    // Registered decode result.
    typedef struct packed {
        nib_t data;
        syn_t syn;
        logic sec;
        logic ded;
    } dec_res_t;
endpackage

// File: rtl/secded4_enc.sv
// Combinational encoder: places the nibble and its four balanced check
// bits into the codeword. Each check bit XORs three data bits.
module secded4_enc
    import secded4_pkg::*;
(
    input  nib_t  data_i,
    output word_t word_o
);
    // Build the codeword from the data bits and the check equations.
    always_comb begin
        word_o         = '0;
        word_o[POS_D3] = data_i[NIB_D3];
        word_o[POS_D5] = data_i[NIB_D5];
        word_o[POS_D6] = data_i[NIB_D6];
        word_o[POS_D7] = data_i[NIB_D7];
        word_o[POS_P1] = data_i[NIB_D3] ^ data_i[NIB_D5] ^ data_i[NIB_D6];
        word_o[POS_P2] = data_i[NIB_D3] ^ data_i[NIB_D5] ^ data_i[NIB_D7];
        word_o[POS_P4] = data_i[NIB_D3] ^ data_i[NIB_D6] ^ data_i[NIB_D7];
        word_o[POS_P8] = data_i[NIB_D5] ^ data_i[NIB_D6] ^ data_i[NIB_D7];
    end
endmodule

// File: rtl/secded4_syn.sv
// Combinational syndrome generator: recomputes each check group over the
// received word, including its stored check bit. Zero means consistent.
module secded4_syn
    import secded4_pkg::*;
(
    input  word_t word_i,
    output syn_t  syn_o
);
    // Four equal-depth parity trees, four inputs each.
    always_comb begin
        syn_o[0] = word_i[POS_P1] ^ word_i[POS_D3] ^ word_i[POS_D5] ^ word_i[POS_D6];
        syn_o[1] = word_i[POS_P2] ^ word_i[POS_D3] ^ word_i[POS_D5] ^ word_i[POS_D7];
        syn_o[2] = word_i[POS_P4] ^ word_i[POS_D3] ^ word_i[POS_D6] ^ word_i[POS_D7];
        syn_o[3] = word_i[POS_P8] ^ word_i[POS_D5] ^ word_i[POS_D6] ^ word_i[POS_D7];
    end
endmodule

// File: rtl/secded4_fix.sv
// Combinational classifier and corrector. The syndrome weight picks the
// case: odd means a single error, nonzero even means a double error. A
// weight-3 pattern names the one data bit whose group is missing from it.
module secded4_fix
    import secded4_pkg::*;
(
    input  word_t word_i,
    input  syn_t  syn_i,
    output nib_t  data_o,
    output logic  sec_o,
    output logic  ded_o
);
    nib_t raw;
    nib_t flip;
    logic [$clog2(SYN_W+1)-1:0] weight;

    // Pull the data bits out of the received word.
    always_comb begin
        raw[NIB_D3] = word_i[POS_D3];
        raw[NIB_D5] = word_i[POS_D5];
        raw[NIB_D6] = word_i[POS_D6];
        raw[NIB_D7] = word_i[POS_D7];
    end

    // Count the ones in the syndrome.
    always_comb begin
        weight = '0;
        for (int i = 0; i < SYN_W; i++) begin
            weight = weight + {{($bits(weight)-1){1'b0}}, syn_i[i]};
        end
    end

    // Classify the error and choose which data bit, if any, to invert.
    always_comb begin
        flip  = '0;
        sec_o = 1'b0;
        ded_o = 1'b0;
        if (syn_i != '0) begin
            if (weight[0]) begin
                sec_o = 1'b1;
                case (syn_i)
                    4'b0111: flip[NIB_D3] = 1'b1;
                    4'b1011: flip[NIB_D5] = 1'b1;
                    4'b1101: flip[NIB_D6] = 1'b1;
                    4'b1110: flip[NIB_D7] = 1'b1;
                    default: flip = '0;
                endcase
            end else begin
                ded_o = 1'b1;
            end
        end
    end

    // Apply the correction.
    assign data_o = raw ^ flip;
endmodule

// File: rtl/secded4_codec.sv
// Top of the codec: an encode path and a decode path, each with one output
// register and a valid strobe. Assumes synchronous active-low reset and a
// single clock for both paths.
module secded4_codec
    import secded4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_vld_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_vld_o,
    output logic [WORD_W-1:0] enc_word_o,
    input  logic              dec_vld_i,
    input  logic [WORD_W-1:0] dec_word_i,
    output logic              dec_vld_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [SYN_W-1:0]  dec_syn_o,
    output logic              dec_sec_o,
    output logic              dec_ded_o
);
    word_t    enc_word_c;
    syn_t     syn_c;
    nib_t     fix_data_c;
    logic     fix_sec_c;
    logic     fix_ded_c;
    dec_res_t dec_q;

    secded4_enc u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_c)
    );

    secded4_syn u_syn (
        .word_i (dec_word_i),
        .syn_o  (syn_c)
    );

    secded4_fix u_fix (
        .word_i (dec_word_i),
        .syn_i  (syn_c),
        .data_o (fix_data_c),
        .sec_o  (fix_sec_c),
        .ded_o  (fix_ded_c)
    );

    // Encode output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_vld_o  <= 1'b0;
            enc_word_o <= '0;
        end else begin
            enc_vld_o <= enc_vld_i;
            if (enc_vld_i) enc_word_o <= enc_word_c;
        end
    end

    // Decode output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld_o <= 1'b0;
            dec_q     <= '0;
        end else begin
            dec_vld_o <= dec_vld_i;
            if (dec_vld_i) dec_q <= '{data: fix_data_c, syn: syn_c, sec: fix_sec_c, ded: fix_ded_c};
        end
    end

    assign dec_data_o = dec_q.data;
    assign dec_syn_o  = dec_q.syn;
    assign dec_sec_o  = dec_q.sec;
    assign dec_ded_o  = dec_q.ded;

    AST_ENC_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) enc_vld_i |=> enc_vld_o); // R2
    AST_ENC_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !enc_vld_i |=> !enc_vld_o); // R2
    AST_DEC_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) dec_vld_i |=> dec_vld_o); // R8
    AST_DEC_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !dec_vld_i |=> !dec_vld_o); // R8
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dec_sec_o && dec_ded_o)); // R9
    AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_syn_o == '0) |-> (!dec_sec_o && !dec_ded_o)); // R4
    AST_SEC_ODD_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_sec_o) |-> ($countones(dec_syn_o) % 2 == 1)); // R5
    AST_DED_EVEN_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && dec_ded_o) |-> (dec_syn_o != '0 && $countones(dec_syn_o) % 2 == 0)); // R7
    AST_CHK_FLIP_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld_o && $countones(dec_syn_o) == 1) |->
        (dec_data_o == {$past(dec_word_i[POS_D3]), $past(dec_word_i[POS_D5]),
                        $past(dec_word_i[POS_D6]), $past(dec_word_i[POS_D7])})); // R5
endmodule

// File: tb/secded4_codec_bench.sv
// Scoreboard bench: driver tasks queue expected results, and a monitor pops
// and compares them each time a strobe appears.
module secded4_codec_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_vld_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_vld_o;
    logic [7:0] enc_word_o;
    logic       dec_vld_i = 1'b0;
    logic [7:0] dec_word_i = '0;
    logic       dec_vld_o;
    logic [3:0] dec_data_o;
    logic [3:0] dec_syn_o;
    logic       dec_sec_o;
    logic       dec_ded_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] data;
        logic [3:0] syn;
        logic       sec;
        logic       ded;
        string      req;
    } exp_t;

    exp_t       dec_q[$];
    logic [7:0] enc_q[$];

    always #5 clk = ~clk;

    secded4_codec u_secded4_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_vld_i(enc_vld_i), .enc_data_i(enc_data_i),
        .enc_vld_o(enc_vld_o), .enc_word_o(enc_word_o),
        .dec_vld_i(dec_vld_i), .dec_word_i(dec_word_i),
        .dec_vld_o(dec_vld_o), .dec_data_o(dec_data_o), .dec_syn_o(dec_syn_o),
        .dec_sec_o(dec_sec_o), .dec_ded_o(dec_ded_o)
    );

    // Reference encoder, written from the R1 equations and bit order.
    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic d3, d5, d6, d7;
        {d3, d5, d6, d7} = d;
        return {d3 ^ d5 ^ d6, d3 ^ d5 ^ d7, d3, d3 ^ d6 ^ d7, d5, d6, d7, d5 ^ d6 ^ d7};
    endfunction

    // Syndrome column for each codeword bit position, from R3: {C8,C4,C2,C1}.
    function automatic logic [3:0] col(input int pos);
        case (pos)
            7: return 4'b0001; // P1
            6: return 4'b0010; // P2
            5: return 4'b0111; // D3
            4: return 4'b0100; // P4
            3: return 4'b1011; // D5
            2: return 4'b1101; // D6
            1: return 4'b1110; // D7
            default: return 4'b1000; // P8
        endcase
    endfunction

    function automatic logic [3:0] raw_data(input logic [7:0] w);
        return {w[5], w[3], w[2], w[1]};
    endfunction

    function automatic int is_data_pos(input int pos);
        return (pos == 5 || pos == 3 || pos == 2 || pos == 1) ? 1 : 0;
    endfunction

    task automatic count(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Driver tasks: present one input for one cycle and queue the expectation.
    task automatic enc_send(input logic [3:0] d);
        @(negedge clk);
        enc_vld_i  = 1'b1;
        enc_data_i = d;
        enc_q.push_back(ref_enc(d));
    endtask

    task automatic dec_send(input logic [7:0] w, input exp_t e);
        @(negedge clk);
        dec_vld_i  = 1'b1;
        dec_word_i = w;
        dec_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        enc_vld_i = 1'b0;
        dec_vld_i = 1'b0;
    endtask

    // Monitor: compare strobed outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && enc_vld_o === 1'b1) begin
                if (enc_q.size() == 0) begin
                    count(1'b0, "R2 unexpected enc_vld_o act=1 exp=0");
                end else begin
                    logic [7:0] ew;
                    ew = enc_q.pop_front();
                    count(enc_word_o === ew,
                        $sformatf("R1 codeword act=%b exp=%b", enc_word_o, ew));
                end
            end
            if (rst_n && dec_vld_o === 1'b1) begin
                if (dec_q.size() == 0) begin
                    count(1'b0, "R8 unexpected dec_vld_o act=1 exp=0");
                end else begin
                    exp_t e;
                    e = dec_q.pop_front();
                    count(dec_data_o === e.data && dec_syn_o === e.syn &&
                          dec_sec_o === e.sec && dec_ded_o === e.ded,
                        $sformatf("%s act data=%b syn=%b sec=%b ded=%b exp data=%b syn=%b sec=%b ded=%b",
                            e.req, dec_data_o, dec_syn_o, dec_sec_o, dec_ded_o,
                            e.data, e.syn, e.sec, e.ded));
                    count(!(dec_sec_o && dec_ded_o),
                        $sformatf("R9 both flags act sec=%b ded=%b exp not both", dec_sec_o, dec_ded_o));
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        count(enc_vld_o === 1'b0, $sformatf("R2 enc strobe in reset act=%b exp=0", enc_vld_o));
        count(dec_vld_o === 1'b0, $sformatf("R8 dec strobe in reset act=%b exp=0", dec_vld_o));
        rst_n = 1'b1;
        @(negedge clk);
        count(enc_vld_o === 1'b0 && dec_vld_o === 1'b0,
            $sformatf("R2 R8 strobes after reset act=%b%b exp=00", enc_vld_o, dec_vld_o));

        // Encode all nibbles; idle after every odd value.
        for (int d = 0; d < 16; d++) begin
            enc_send(d[3:0]);
            if (d[0]) idle();
        end
        idle();
        @(negedge clk);
        count(enc_vld_o === 1'b0, $sformatf("R2 enc strobe when idle act=%b exp=0", enc_vld_o));

        // Decode: clean, every single flip, every double flip.
        for (int d = 0; d < 16; d++) begin
            logic [7:0] cw;
            exp_t e;
            cw = ref_enc(d[3:0]);
            e = '{data: d[3:0], syn: 4'b0, sec: 1'b0, ded: 1'b0, req: "R4 clean"};
            dec_send(cw, e);
            for (int i = 0; i < 8; i++) begin
                e = '{data: d[3:0], syn: col(i), sec: 1'b1, ded: 1'b0,
                      req: is_data_pos(i) ? $sformatf("R6 R3 data flip pos%0d", i)
                                          : $sformatf("R5 R3 check flip pos%0d", i)};
                dec_send(cw ^ (8'b1 << i), e);
            end
            for (int i = 0; i < 8; i++) begin
                for (int j = i + 1; j < 8; j++) begin
                    logic [7:0] bad;
                    bad = cw ^ (8'b1 << i) ^ (8'b1 << j);
                    e = '{data: raw_data(bad), syn: col(i) ^ col(j), sec: 1'b0, ded: 1'b1,
                          req: $sformatf("R7 R3 double flip pos%0d pos%0d", i, j)};
                    dec_send(bad, e);
                end
            end
            idle();
            @(negedge clk);
            count(dec_vld_o === 1'b0, $sformatf("R8 dec strobe when idle act=%b exp=0", dec_vld_o));
        end

        repeat (4) idle();
        count(dec_q.size() == 0 && enc_q.size() == 0,
            $sformatf("R2 R8 missing strobes act=%0d/%0d pending exp=0/0", enc_q.size(), dec_q.size()));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule